// File: doc/BRIEF.md
# Time-of-Day Control Unit

This block is the per-chip controller that tracks whether the chip's time-of-day value can be trusted. It has a small state machine with four states: error, value not yet set, stopped and running. Software moves it between states by writing command words to a 64-bit register port. Peer chips move it by sending single-cycle "invalidate" and "send time" triggers. The block can also issue those two triggers to its peers, through a register write. The triggers never loop back to the sender.

Software reads a status word, an FSM word, a master/slave control shadow and a hardware error register through the same port. The port uses word offsets. Bit numbers in this document count from the most significant end: bit 0 is `regWrData[63]` and bit 63 is `regWrData[0]`. Any command that the current state does not allow leaves the state unchanged and raises a one-cycle illegal-command flag. An error event from the chip's checkers forces the error state and is latched in the error register until software clears it.

Top module: `timeofday_ctrl`

## Requirements
- R1: After reset the state is 0 (error) and `illegalCmd`, `bcastSend`, `bcastInval` and `rdValid` are 0. The error register reads 0. The control register (offset 0x07) reads with only bit 2 set, plus bit 1 when `cfgPrimary` is 1.
- R2: Any set bit of `errEvent` forces state 0 at the next edge from every state. This overrides peer triggers and register commands in the same cycle.
- R3: A write to offset 0x18 moves the state to 7 (not set) from any state when bit 0 (`regWrData[63]`) is 1. The write is rejected when that bit is 0.
- R4: A write to offset 0x21 is accepted only in state 7. It moves the state to 1 (stopped) when bit 63 (`regWrData[0]`) is 1, and to 2 (running) when that bit is 0.
- R5: A write to offset 0x22 moves state 1 to state 2. The write is rejected in every other state.
- R6: A `peerInvalIn` pulse moves any state to 7. A `peerSendIn` pulse moves state 7 to 2 and is rejected in other states. Invalidate wins over send. Either peer trigger wins over a state command written in the same cycle; that command is dropped and raises no flag.
- R7: A write to offset 0x15 gives a one-cycle `bcastSend` pulse in the next cycle. A write to offset 0x16 gives a one-cycle `bcastInval` pulse in the next cycle. Neither write changes the local state.
- R8: A read of offset 0x24 returns only bit 4 (`regRdData[59]`) set while the state is 2, and 0 otherwise.
- R9: A read of offset 0x08 always has bits 6 to 10, 12, 21 and 26 set, and has bit 20 set while the state is 2. It has exactly one role bit set: bit 23 if `cfgPrimary`, else bit 24 if `cfgSecondary`, else bit 25.
- R10: A write to offset 0x07 keeps bits 0 to 31 (`regWrData[63:32]`) and reads them back in the same positions, with bits 32 to 63 reading 0. Bit 1 always reads as `cfgPrimary` and bit 2 always reads as 1.
- R11: The error register (offset 0x30, `ERR_W` low bits `regRdData[ERR_W-1:0]`) sets each bit for which `errEvent` is 1. A write clears each bit where the written value is 1. A set and a clear of the same bit in one cycle leave the bit set.
- R12: A rejected command leaves the state unchanged and makes `illegalCmd` 1 for exactly the one cycle after the command's edge.
- R13: `rdValid` is 1 in the cycle after `regRdEn`, and `regRdData` holds the value read in that cycle. A read of an unimplemented offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Word offset of the access |
| regWrData | input | 64 | Write data, bit 0 is the MSB |
| regRdData | output | 64 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after regRdEn |
| peerSendIn | input | 1 | Send-time trigger pulse from a peer chip |
| peerInvalIn | input | 1 | Invalidate trigger pulse from a peer chip |
| bcastSend | output | 1 | Send-time trigger pulse to peers |
| bcastInval | output | 1 | Invalidate trigger pulse to peers |
| errEvent | input | ERR_W | Hardware error events |
| cfgPrimary | input | 1 | Chip is configured as the primary master |
| cfgSecondary | input | 1 | Chip is configured as the backup master |
| fsmState | output | 3 | Current state code (0, 1, 2 or 7) |
| illegalCmd | output | 1 | One-cycle pulse on a rejected command |

## Verification
The bench checks every state command in the states where it must be refused. A design that checked the wrong state or the wrong command bit would change state there instead of pulsing `illegalCmd`.

It collides a peer invalidate with a command that would otherwise be rejected, and an error event with a peer invalidate. A wrong priority order would show as a stray flag or a wrong final state.

It sets and clears the same error bit in one cycle, writes the control register under both role settings, and reads the status word for all four role combinations. Those reads catch a lost forced bit, a cleared bit that should stay set, or two role bits set at once.

Broadcast writes are made while the state is running, so a trigger that looped back to the sender would move the local state.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  localparam int DATA_W   = 64;
  localparam int CTRL_W   = 32;

  // Register word offsets
  localparam int OFS_CTRL     = 'h07;
  localparam int OFS_STATUS   = 'h08;
  localparam int OFS_SEND     = 'h15;
  localparam int OFS_INVAL    = 'h16;
  localparam int OFS_LOAD_MOD = 'h18;
  localparam int OFS_LOAD     = 'h21;
  localparam int OFS_START    = 'h22;
  localparam int OFS_FSM      = 'h24;
  localparam int OFS_ERR      = 'h30;

  typedef enum logic [2:0] {
    TS_ERROR   = 3'd0,
    TS_STOPPED = 3'd1,
    TS_RUNNING = 3'd2,
    TS_NOTSET  = 3'd7
  } todState_e;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_LOAD_MOD,
    CMD_LOAD,
    CMD_START
  } cmd_e;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_CTRL,
    RD_FSM,
    RD_ERR
  } rdSel_e;

  typedef struct packed {
    logic   ctrlWr;
    logic   errClr;
    logic   sendBcast;
    logic   invalBcast;
    logic   rdEn;
    rdSel_e rdSel;
  } strobe_t;

  // Convert an MSB-first bit number into a vector index
  function automatic int beBit(input int n);
    return DATA_W - 1 - n;
  endfunction

endpackage

// File: rtl/tdc_ctrl.sv
module tdc_ctrl
  import tdc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrMsb,
  input  logic              wrLsb,
  input  logic              errAny,
  input  logic              peerSendIn,
  input  logic              peerInvalIn,
  output todState_e         state,
  output logic              illegalCmd,
  output strobe_t           stb
);

  localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STATUS   = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_SEND     = ADDR_W'(OFS_SEND);
  localparam logic [ADDR_W-1:0] A_INVAL    = ADDR_W'(OFS_INVAL);
  localparam logic [ADDR_W-1:0] A_LOAD_MOD = ADDR_W'(OFS_LOAD_MOD);
  localparam logic [ADDR_W-1:0] A_LOAD     = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_START    = ADDR_W'(OFS_START);
  localparam logic [ADDR_W-1:0] A_FSM      = ADDR_W'(OFS_FSM);
  localparam logic [ADDR_W-1:0] A_ERR      = ADDR_W'(OFS_ERR);

  cmd_e      cmd;
  todState_e nxtState;
  logic      reject;

  // Command decode
  always_comb begin
    cmd = CMD_NONE;
    if (regWrEn) begin
      case (regAddr)
        A_LOAD_MOD: cmd = CMD_LOAD_MOD;
        A_LOAD:     cmd = CMD_LOAD;
        A_START:    cmd = CMD_START;
        default:    cmd = CMD_NONE;
      endcase
    end
  end

  // Strobes towards the datapath
  always_comb begin
    stb.ctrlWr     = regWrEn && (regAddr == A_CTRL);
    stb.errClr     = regWrEn && (regAddr == A_ERR);
    stb.sendBcast  = regWrEn && (regAddr == A_SEND);
    stb.invalBcast = regWrEn && (regAddr == A_INVAL);
    stb.rdEn       = regRdEn;
    case (regAddr)
      A_STATUS: stb.rdSel = RD_STATUS;
      A_CTRL:   stb.rdSel = RD_CTRL;
      A_FSM:    stb.rdSel = RD_FSM;
      A_ERR:    stb.rdSel = RD_ERR;
      default:  stb.rdSel = RD_NONE;
    endcase
  end

  // Next state: error, then peer invalidate, then peer send, then local command
  always_comb begin
    nxtState = state;
    reject   = 1'b0;
    if (errAny) begin
      nxtState = TS_ERROR;
    end else if (peerInvalIn) begin
      nxtState = TS_NOTSET;
    end else if (peerSendIn) begin
      if (state == TS_NOTSET) nxtState = TS_RUNNING;
      else                    reject   = 1'b1;
    end else begin
      case (cmd)
        CMD_LOAD_MOD: begin
          if (wrMsb) nxtState = TS_NOTSET;
          else       reject   = 1'b1;
        end
        CMD_LOAD: begin
          if (state == TS_NOTSET) nxtState = wrLsb ? TS_STOPPED : TS_RUNNING;
          else                    reject   = 1'b1;
        end
        CMD_START: begin
          if (state == TS_STOPPED) nxtState = TS_RUNNING;
          else                     reject   = 1'b1;
        end
        default: nxtState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= TS_ERROR;
      illegalCmd <= 1'b0;
    end else begin
      state      <= nxtState;
      illegalCmd <= reject;
    end
  end

endmodule

// File: rtl/tdc_regs.sv
module tdc_regs
  import tdc_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [CTRL_W-1:0] ctrlData,
  input  logic [ERR_W-1:0]  errClrData,
  input  logic [ERR_W-1:0]  errEvent,
  input  logic              running,
  input  logic              cfgPrimary,
  input  logic              cfgSecondary,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              bcastSend,
  output logic              bcastInval
);

  // Control shadow: MSB-first bit 0 and bits 3..31 are stored, bits 1 and 2 forced
  localparam int LO_W = CTRL_W - 3;

  function automatic logic [DATA_W-1:0] statusBase();
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 6; i <= 10; i++) v[beBit(i)] = 1'b1;
    v[beBit(12)] = 1'b1;
    v[beBit(21)] = 1'b1;
    v[beBit(26)] = 1'b1;
    return v;
  endfunction

  localparam logic [DATA_W-1:0] STATUS_BASE = statusBase();

  logic              ctrlHi;
  logic [LO_W-1:0]   ctrlLo;
  logic [ERR_W-1:0]  errQ;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] ctrlWord;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlHi <= 1'b0;
      ctrlLo <= '0;
    end else if (stb.ctrlWr) begin
      ctrlHi <= ctrlData[CTRL_W-1];
      ctrlLo <= ctrlData[LO_W-1:0];
    end
  end

  // Error bits: set wins over a same-cycle clear
  for (genvar i = 0; i < ERR_W; i++) begin : g_err
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             errQ[i] <= 1'b0;
      else if (errEvent[i])                  errQ[i] <= 1'b1;
      else if (stb.errClr && errClrData[i])  errQ[i] <= 1'b0;
    end
  end

  always_comb begin
    statusWord = STATUS_BASE;
    if (running) statusWord[beBit(20)] = 1'b1;
    if (cfgPrimary)        statusWord[beBit(23)] = 1'b1;
    else if (cfgSecondary) statusWord[beBit(24)] = 1'b1;
    else                   statusWord[beBit(25)] = 1'b1;
  end

  assign ctrlWord = {ctrlHi, cfgPrimary, 1'b1, ctrlLo, {(DATA_W-CTRL_W){1'b0}}};

  always_comb begin
    case (stb.rdSel)
      RD_STATUS: rdNext = statusWord;
      RD_CTRL:   rdNext = ctrlWord;
      RD_FSM:    rdNext = running ? (DATA_W'(1) << beBit(4)) : '0;
      RD_ERR:    rdNext = DATA_W'(errQ);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData     <= '0;
      rdValid    <= 1'b0;
      bcastSend  <= 1'b0;
      bcastInval <= 1'b0;
    end else begin
      rdData     <= stb.rdEn ? rdNext : '0;
      rdValid    <= stb.rdEn;
      bcastSend  <= stb.sendBcast;
      bcastInval <= stb.invalBcast;
    end
  end

endmodule

// File: rtl/timeofday_ctrl.sv
module timeofday_ctrl
  import tdc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              rdValid,
  input  logic              peerSendIn,
  input  logic              peerInvalIn,
  output logic              bcastSend,
  output logic              bcastInval,
  input  logic [ERR_W-1:0]  errEvent,
  input  logic              cfgPrimary,
  input  logic              cfgSecondary,
  output logic [2:0]        fsmState,
  output logic              illegalCmd
);

  todState_e state;
  strobe_t   stb;
  logic      unusedWrAll;

  assign unusedWrAll = ^regWrData;

  tdc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .wrMsb      (regWrData[DATA_W-1]),
    .wrLsb      (regWrData[0]),
    .errAny     (|errEvent),
    .peerSendIn (peerSendIn),
    .peerInvalIn(peerInvalIn),
    .state      (state),
    .illegalCmd (illegalCmd),
    .stb        (stb)
  );

  tdc_regs #(.ERR_W(ERR_W)) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .ctrlData    (regWrData[DATA_W-1:DATA_W-CTRL_W]),
    .errClrData  (regWrData[ERR_W-1:0]),
    .errEvent    (errEvent),
    .running     (state == TS_RUNNING),
    .cfgPrimary  (cfgPrimary),
    .cfgSecondary(cfgSecondary),
    .rdData      (regRdData),
    .rdValid     (rdValid),
    .bcastSend   (bcastSend),
    .bcastInval  (bcastInval)
  );

  assign fsmState = state;

endmodule

// File: rtl/tdc_chk.sv
module tdc_chk
  import tdc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wrMsb,
  input logic              wrLsb,
  input logic [DATA_W-1:0] regRdData,
  input logic              rdValid,
  input logic              peerSendIn,
  input logic              peerInvalIn,
  input logic              bcastSend,
  input logic              bcastInval,
  input logic              errAny,
  input logic [2:0]        fsmState,
  input logic              illegalCmd
);

  logic quiet;
  assign quiet = !errAny && !peerSendIn && !peerInvalIn;

  // R1
  state_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    fsmState inside {3'd0, 3'd1, 3'd2, 3'd7});

  // R2
  err_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    errAny |=> fsmState == 3'd0);

  // R3
  load_mod_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == ADDR_W'(OFS_LOAD_MOD) && wrMsb && quiet |=> fsmState == 3'd7);

  // R4
  load_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == ADDR_W'(OFS_LOAD) && fsmState == 3'd7 && wrLsb && quiet
    |=> fsmState == 3'd1);

  // R5
  start_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == ADDR_W'(OFS_START) && fsmState != 3'd1 && quiet |=> illegalCmd);

  // R6
  peer_inval_chk: assert property (@(posedge clk) disable iff (!rstN)
    peerInvalIn && !errAny |=> fsmState == 3'd7 && !illegalCmd);

  // R7
  bcast_send_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == ADDR_W'(OFS_SEND) && quiet |=> bcastSend && $stable(fsmState));

  // R7
  bcast_inval_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == ADDR_W'(OFS_INVAL) && quiet |=> bcastInval && $stable(fsmState));

  // R8
  fsm_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && $past(regAddr) == ADDR_W'(OFS_FSM)
    |-> regRdData == (($past(fsmState) == 3'd2) ? (DATA_W'(1) << beBit(4)) : '0));

  // R12
  illegal_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalCmd |-> $stable(fsmState));

  // R13
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> rdValid);

  // R13
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> !rdValid);

endmodule

bind timeofday_ctrl tdc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regRdEn    (regRdEn),
  .regAddr    (regAddr),
  .wrMsb      (regWrData[63]),
  .wrLsb      (regWrData[0]),
  .regRdData  (regRdData),
  .rdValid    (rdValid),
  .peerSendIn (peerSendIn),
  .peerInvalIn(peerInvalIn),
  .bcastSend  (bcastSend),
  .bcastInval (bcastInval),
  .errAny     (|errEvent),
  .fsmState   (fsmState),
  .illegalCmd (illegalCmd)
);

// File: tb/sim_timeofday_ctrl.sv
module sim_timeofday_ctrl;

  localparam int AW = 6;
  localparam int EW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic          regRdEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [63:0]   regWrData = '0;
  logic [63:0]   regRdData;
  logic          rdValid;
  logic          peerSendIn = 1'b0;
  logic          peerInvalIn = 1'b0;
  logic          bcastSend;
  logic          bcastInval;
  logic [EW-1:0] errEvent = '0;
  logic          cfgPrimary = 1'b1;
  logic          cfgSecondary = 1'b0;
  logic [2:0]    fsmState;
  logic          illegalCmd;

  int nTests = 0;
  int nFails = 0;
  bit finished = 1'b0;

  logic [63:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  timeofday_ctrl #(.ADDR_W(AW), .ERR_W(EW)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .rdValid(rdValid),
    .peerSendIn(peerSendIn), .peerInvalIn(peerInvalIn), .bcastSend(bcastSend),
    .bcastInval(bcastInval), .errEvent(errEvent), .cfgPrimary(cfgPrimary),
    .cfgSecondary(cfgSecondary), .fsmState(fsmState), .illegalCmd(illegalCmd)
  );

  function automatic logic [63:0] bb(input int n);
    return 64'd1 << (63 - n);
  endfunction

  function automatic logic [63:0] statusExp(input bit run, input bit pri, input bit sec);
    logic [63:0] v;
    v = bb(12) | bb(21) | bb(26);
    for (int i = 6; i <= 10; i++) v = v | bb(i);
    if (run) v = v | bb(20);
    if (pri)      v = v | bb(23);
    else if (sec) v = v | bb(24);
    else          v = v | bb(25);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rdValid) begin
      if (expQ.size() == 0) chk("R13 rdValid without a read", 64'd1, 64'd0);
      else                  chk(tagQ.pop_front(), regRdData, expQ.pop_front());
    end
  end

  task automatic wr(input int ofs, input logic [63:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = AW'(ofs); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input int ofs, input logic [63:0] e, input string tag);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = AW'(ofs);
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic peer(input bit s, input bit i);
    @(negedge clk);
    peerSendIn = s; peerInvalIn = i;
    @(negedge clk);
    peerSendIn = 1'b0; peerInvalIn = 1'b0;
  endtask

  task automatic expectReject(input string tag, input logic [2:0] st);
    chk({tag, " state"}, 64'(fsmState), 64'(st));
    chk({tag, " illegal pulse"}, 64'(illegalCmd), 64'd1);
    @(negedge clk);
    chk({tag, " illegal drops"}, 64'(illegalCmd), 64'd0);
  endtask

  task automatic expectMove(input string tag, input logic [2:0] st);
    chk({tag, " state"}, 64'(fsmState), 64'(st));
    chk({tag, " no illegal"}, 64'(illegalCmd), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 state", 64'(fsmState), 64'd0);
    chk("R1 illegal", 64'(illegalCmd), 64'd0);
    chk("R1 bcast", 64'({bcastSend, bcastInval}), 64'd0);
    chk("R1 rdValid", 64'(rdValid), 64'd0);
    rd('h07, bb(1) | bb(2), "R1 ctrl reset");
    rd('h30, 64'd0, "R1 err reset");
    rd('h24, 64'd0, "R8 fsm in error");

    // Rejections from the error state
    wr('h22, 64'd0);                  expectReject("R5 start in error", 3'd0);
    wr('h21, 64'd1);                  expectReject("R4 load in error", 3'd0);
    wr('h18, 64'h7FFF_FFFF_FFFF_FFFF); expectReject("R3 load_mod msb clear", 3'd0);
    peer(1'b1, 1'b0);                 expectReject("R6 peer send in error", 3'd0);
    wr('h18, 64'h8000_0000_0000_0000); expectMove("R3 load_mod", 3'd7);
    wr('h22, 64'd0);                  expectReject("R5 start in notset", 3'd7);
    wr('h21, 64'd1);                  expectMove("R4 load stopped", 3'd1);
    rd('h24, 64'd0, "R8 fsm stopped");
    rd('h08, statusExp(0, 1, 0), "R9 status stopped");
    wr('h21, 64'd0);                  expectReject("R4 load in stopped", 3'd1);
    wr('h22, 64'd0);                  expectMove("R5 start", 3'd2);
    rd('h24, bb(4), "R8 fsm running");
    rd('h08, statusExp(1, 1, 0), "R9 status running");
    wr('h22, 64'd0);                  expectReject("R5 start in running", 3'd2);

    // R7 broadcasts leave local state alone
    wr('h15, 64'd0);
    chk("R7 send pulse", 64'({bcastSend, bcastInval}), 64'd2);
    chk("R7 send no self effect", 64'(fsmState), 64'd2);
    @(negedge clk);
    chk("R7 send pulse ends", 64'(bcastSend), 64'd0);
    wr('h16, 64'd0);
    chk("R7 inval pulse", 64'({bcastSend, bcastInval}), 64'd1);
    chk("R7 inval no self effect", 64'(fsmState), 64'd2);
    @(negedge clk);
    chk("R7 inval pulse ends", 64'(bcastInval), 64'd0);

    // R6 peer triggers
    peer(1'b0, 1'b1);                 expectMove("R6 peer inval", 3'd7);
    peer(1'b1, 1'b0);                 expectMove("R6 peer send", 3'd2);
    peer(1'b1, 1'b1);                 expectMove("R6 inval beats send", 3'd7);
    peer(1'b1, 1'b0);                 expectMove("R6 peer send again", 3'd2);
    // Peer invalidate collides with a start that would be rejected
    @(negedge clk);
    peerInvalIn = 1'b1; regWrEn = 1'b1; regAddr = AW'('h22);
    @(negedge clk);
    peerInvalIn = 1'b0; regWrEn = 1'b0;
    expectMove("R6 peer beats local", 3'd7);
    wr('h21, 64'd0);                  expectMove("R4 load running", 3'd2);

    // R2 and R11 error handling
    @(negedge clk);
    errEvent = 16'h0005;
    @(negedge clk);
    errEvent = '0;
    expectMove("R2 error from running", 3'd0);
    rd('h30, 64'h5, "R11 err set");
    wr('h30, 64'h1);
    rd('h30, 64'h4, "R11 err clear");
    @(negedge clk);
    errEvent = 16'h0002; regWrEn = 1'b1; regAddr = AW'('h30); regWrData = 64'h2;
    @(negedge clk);
    errEvent = '0; regWrEn = 1'b0; regWrData = '0;
    rd('h30, 64'h6, "R11 set wins over clear");
    wr('h18, 64'h8000_0000_0000_0000);
    @(negedge clk);
    errEvent = 16'h8000; peerInvalIn = 1'b1;
    @(negedge clk);
    errEvent = '0; peerInvalIn = 1'b0;
    expectMove("R2 error beats peer", 3'd0);

    // R10 control shadow
    wr('h07, 64'hFFFF_FFFF_FFFF_FFFF);
    rd('h07, 64'hFFFF_FFFF_0000_0000, "R10 ctrl primary");
    cfgPrimary = 1'b0;
    wr('h07, 64'hFFFF_FFFF_FFFF_FFFF);
    rd('h07, 64'hBFFF_FFFF_0000_0000, "R10 ctrl non-primary");
    wr('h07, 64'd0);
    rd('h07, bb(2), "R10 ctrl forced bit");

    // R9 role bits
    cfgSecondary = 1'b1;
    rd('h08, statusExp(0, 0, 1), "R9 status secondary");
    cfgSecondary = 1'b0;
    rd('h08, statusExp(0, 0, 0), "R9 status slave");
    cfgPrimary = 1'b1; cfgSecondary = 1'b1;
    rd('h08, statusExp(0, 1, 1), "R9 status both roles");

    // R13 unimplemented offset and read timing
    rd('h27, 64'd0, "R13 unimplemented");
    chk("R13 rdValid one cycle", 64'(rdValid), 64'd1);
    @(negedge clk);
    chk("R13 rdValid drops", 64'(rdValid), 64'd0);

    repeat (2) @(negedge clk);
    chk("R13 all reads returned", 64'(expQ.size()), 64'd0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

endmodule